// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

A single-port synchronous static memory with a registered read path and a byte-writable data bus. Every control and address input is captured on the rising clock edge. Read data leaves through an output register, so a word requested at one edge reaches the bus after the following edge. An asynchronous output enable gates the bus drivers. The bus is split into separate input data, output data and drive-enable ports.

Two address strobes can open an access. The processor strobe always starts a read, and that read becomes a write on the next edge if write controls are then presented. The controller strobe performs a write in the same edge. A two-bit burst counter steps through four aligned words, in either linear or interleaved order, under an active-low advance input. Outputs are held off in the first cycle after selection and while a write is under way. A deselect turns the outputs off one cycle late, which gives double-cycle deselect.

Top module: `burst_sram`

## Requirements
- R1: While `rst_n` is low and after it rises with no strobe asserted, the device is deselected and `dout_en` stays 0.
- R2: A read starts at an edge where a strobe is low, `sel_n` and `sel2_n` are both low, and `gw_n` and `bwe_n` are both high. After the next edge, `dout` holds the addressed word and `dout_en` equals `!oe_n`.
- R3: A low `cpu_strb_n` sampled while `sel_n` is high (with `ctl_strb_n` high) changes nothing: the address held and the data driven stay the same.
- R4: When an access starts from the deselected state, `dout_en` is 0 between that edge and the next one, even with `oe_n` low.
- R5: A strobe sampled with the chip not fully selected deselects it. `dout_en` keeps its value after that edge and is 0 after the edge that follows.
- R6: At a processor-strobe edge the write inputs are ignored and nothing is written. At the next edge with no strobe, active write controls store `din` at the captured address.
- R7: A controller-strobe write needs `cpu_strb_n` high (a low `cpu_strb_n` with `sel_n` low makes the edge a read). It writes in the same edge at `addr`, and `adv_n` is ignored in that edge.
- R8: A low `gw_n` at a write edge writes every lane, whatever `bwe_n` and `bsel_n` are.
- R9: A byte write (`gw_n` high, `bwe_n` low) writes lane i, which is `din[8*i+7:8*i]`, only when `bsel_n[i]` is low. Other lanes keep their old contents.
- R10: After any write edge, `dout_en` is 0 for the following cycle, whatever `oe_n` is.
- R11: `dout_en` follows `oe_n` combinationally whenever the output register holds valid read data.
- R12: A low `adv_n` on a continuation edge steps the burst count n, which wraps modulo 4, and changes only address bits [1:0]. With `lin_order`=1 these bits are (base+n) mod 4; with `lin_order`=0 they are base XOR n.
- R13: At an edge with no strobe and `adv_n` high, the access address is held and the output register is reloaded from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | ADDR_W | Word address |
| cpu_strb_n | input | 1 | Processor address strobe, active low |
| ctl_strb_n | input | 1 | Controller address strobe, active low |
| sel_n | input | 1 | Primary chip select, active low; gates the processor strobe |
| sel2_n | input | 1 | Secondary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| gw_n | input | 1 | Global write, active low |
| bwe_n | input | 1 | Byte write enable, active low |
| bsel_n | input | LANES | Per-lane byte select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Registered read data |
| dout_en | output | 1 | Bus drive enable |

## Verification
Writes take effect at the edge that carries their controls. That is the same edge for the controller strobe and the edge after the strobe for the processor strobe, so a read that starts one edge later returns the new word. Read data and the drive enable are due one edge after the read starts. The three-state rules act one edge late (first cycle after selection, write) or two edges late (deselect). The bench drives inputs on the falling edge and samples outputs at the next falling edge after each rising edge. It checks each result at the exact falling edge that these latencies give, against a shadow memory updated from the write rules.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;

  // Kind of cycle decoded at a rising edge
  typedef enum logic [2:0] {
    CYC_NONE,
    CYC_CPU,
    CYC_CTL,
    CYC_DESEL,
    CYC_CONT
  } cyc_t;

  // Low two address bits of burst step n from a base
  function automatic logic [1:0] burst_low(input logic [1:0] base,
                                           input logic [1:0] n,
                                           input logic       lin);
    return lin ? (base + n) : (base ^ n);
  endfunction

  // Any write control asserted (active low inputs)
  function automatic logic wr_request(input logic gw_n, input logic bwe_n);
    return !gw_n || !bwe_n;
  endfunction

  // Lane write strobe for one lane
  function automatic logic lane_write(input logic gw_n, input logic bwe_n,
                                      input logic bsel_n_i);
    return !gw_n || (!bwe_n && !bsel_n_i);
  endfunction

endpackage

// File: rtl/burst_sram_decode.sv
module burst_sram_decode
  import burst_sram_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cpu_strb_n,
  input  logic             ctl_strb_n,
  input  logic             sel_n,
  input  logic             sel2_n,
  input  logic             gw_n,
  input  logic             bwe_n,
  input  logic [LANES-1:0] bsel_n,
  output cyc_t             cyc,
  output logic             act_q,
  output logic             start_new,
  output logic             do_write,
  output logic             do_read,
  output logic [LANES-1:0] lane_we
);

  logic cpu_hit;
  logic both_sel;
  logic wr_req;
  logic rw_cycle;

  assign cpu_hit  = !cpu_strb_n && !sel_n;
  assign both_sel = !sel_n && !sel2_n;
  assign wr_req   = wr_request(gw_n, bwe_n);

  always_comb begin
    cyc = CYC_NONE;
    if (cpu_hit)          cyc = both_sel ? CYC_CPU : CYC_DESEL;
    else if (!ctl_strb_n) cyc = both_sel ? CYC_CTL : CYC_DESEL;
    else if (act_q)       cyc = CYC_CONT;
  end

  assign start_new = (cyc == CYC_CPU) || (cyc == CYC_CTL);
  assign rw_cycle  = (cyc == CYC_CTL) || (cyc == CYC_CONT);
  assign do_write  = rw_cycle && wr_req;
  assign do_read   = (cyc == CYC_CPU) || (rw_cycle && !wr_req);

  for (genvar i = 0; i < LANES; i++) begin : g_lane_we
    assign lane_we[i] = do_write && lane_write(gw_n, bwe_n, bsel_n[i]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                 act_q <= 1'b0;
    else if (start_new)         act_q <= 1'b1;
    else if (cyc == CYC_DESEL)  act_q <= 1'b0;
  end

endmodule

// File: rtl/burst_sram_addr.sv
module burst_sram_addr
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cyc_t              cyc,
  input  logic [ADDR_W-1:0] addr,
  input  logic              adv_n,
  input  logic              lin_order,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] acc_q
);

  localparam int HI_W = ADDR_W - 2;

  logic [ADDR_W-1:0] base_q;
  logic [1:0]        cnt_q;
  logic [1:0]        cnt_nx;
  logic              is_start;

  assign is_start = (cyc == CYC_CPU) || (cyc == CYC_CTL);
  assign cnt_nx   = adv_n ? cnt_q : cnt_q + 2'd1;

  always_comb begin
    eff_addr = acc_q;
    if (is_start)
      eff_addr = addr;
    else if (cyc == CYC_CONT)
      eff_addr = {base_q[ADDR_W-1:2], burst_low(base_q[1:0], cnt_nx, lin_order)};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (is_start) begin
      base_q <= addr;
      cnt_q  <= '0;
      acc_q  <= addr;
    end else if (cyc == CYC_CONT) begin
      cnt_q  <= cnt_nx;
      acc_q  <= eff_addr;
    end
  end

  // R13: a continuation edge without advance keeps the access address
  a_r13_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_CONT && adv_n) |=> (acc_q == $past(acc_q)));

  // R12: bursting never leaves the aligned group of four
  a_r12_burst_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_CONT) |=> (acc_q[ADDR_W-1:2] == $past(acc_q[ADDR_W-1:2])));

  logic [HI_W-1:0] unused_hi;
  assign unused_hi = base_q[ADDR_W-1:2];

endmodule

// File: rtl/burst_sram_array.sv
module burst_sram_array #(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                      clk,
  input  logic [LANES-1:0]          lane_we,
  input  logic [ADDR_W-1:0]         waddr,
  input  logic [LANES*LANE_W-1:0]   wdata,
  input  logic [ADDR_W-1:0]         raddr,
  output logic [LANES*LANE_W-1:0]   rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
      if (lane_we[i]) mem[waddr] <= wdata[i*LANE_W +: LANE_W];
    end

    assign rdata[i*LANE_W +: LANE_W] = mem[raddr];
  end

endmodule

// File: rtl/burst_sram.sv
module burst_sram
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    cpu_strb_n,
  input  logic                    ctl_strb_n,
  input  logic                    sel_n,
  input  logic                    sel2_n,
  input  logic                    adv_n,
  input  logic                    lin_order,
  input  logic                    gw_n,
  input  logic                    bwe_n,
  input  logic [LANES-1:0]        bsel_n,
  input  logic                    oe_n,
  input  logic [LANES*LANE_W-1:0] din,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);

  localparam int DATA_W = LANES * LANE_W;

  cyc_t              cyc;
  logic              act_q;
  logic              start_new;
  logic              do_write;
  logic              do_read;
  logic [LANES-1:0]  lane_we;
  logic [ADDR_W-1:0] eff_addr;
  logic [ADDR_W-1:0] acc_q;
  logic [DATA_W-1:0] rdata;
  logic [DATA_W-1:0] dout_q;
  logic              rd_q;
  logic              drive_q;

  burst_sram_decode #(.LANES(LANES)) u_decode (
    .clk(clk), .rst_n(rst_n),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .sel_n(sel_n), .sel2_n(sel2_n),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n),
    .cyc(cyc), .act_q(act_q), .start_new(start_new),
    .do_write(do_write), .do_read(do_read), .lane_we(lane_we)
  );

  burst_sram_addr #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .cyc(cyc), .addr(addr),
    .adv_n(adv_n), .lin_order(lin_order),
    .eff_addr(eff_addr), .acc_q(acc_q)
  );

  burst_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .lane_we(lane_we), .waddr(eff_addr), .wdata(din),
    .raddr(acc_q), .rdata(rdata)
  );

  // Output pipeline: access at edge k -> data register at edge k+1
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q    <= 1'b0;
      drive_q <= 1'b0;
      dout_q  <= '0;
    end else begin
      rd_q    <= do_read;
      drive_q <= rd_q && !do_write;
      if (rd_q) dout_q <= rdata;
    end
  end

  assign dout    = dout_q;
  assign dout_en = drive_q && !oe_n;

  // R10: bus is quiet in the cycle after a write edge
  a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    do_write |=> !dout_en);

  // R5: deselect turns drivers off one edge late
  a_r5_late_deselect: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_DESEL) |-> ##2 !dout_en);

  // R4: first cycle after selection from idle stays off
  a_r4_first_cycle_off: assert property (@(posedge clk) disable iff (!rst_n)
    (start_new && !act_q) |=> !dout_en);

  // R6: processor strobe edge never writes the array
  a_r6_cpu_start_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc == CYC_CPU) |-> (lane_we == '0));

  // R8: global write reaches every lane
  a_r8_global_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    (do_write && !gw_n) |-> (&lane_we));

endmodule

// File: tb/burst_sram_tb.sv
module burst_sram_tb;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 6;
  localparam int NL = 2;
  localparam int LW = 8;
  localparam int DW = NL * LW;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] addr;
  logic          cpu_strb_n, ctl_strb_n, sel_n, sel2_n, adv_n, lin_order;
  logic          gw_n, bwe_n, oe_n;
  logic [NL-1:0] bsel_n;
  logic [DW-1:0] din, dout;
  logic          dout_en;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] shadow [DEPTH];

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_dut (
    .clk(clk), .rst_n(rst_n), .addr(addr),
    .cpu_strb_n(cpu_strb_n), .ctl_strb_n(ctl_strb_n),
    .sel_n(sel_n), .sel2_n(sel2_n), .adv_n(adv_n), .lin_order(lin_order),
    .gw_n(gw_n), .bwe_n(bwe_n), .bsel_n(bsel_n), .oe_n(oe_n),
    .din(din), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [DW-1:0] pattern(input int a);
    logic [7:0] hi, lo;
    hi = 8'((a * 7) + 3);
    lo = 8'(a) ^ 8'hA5;
    return {hi, lo};
  endfunction

  function automatic logic [AW-1:0] burst_at(input logic [AW-1:0] base, input int n, input logic lin);
    int lo;
    lo = lin ? ((int'(base[1:0]) + n) % 4) : (int'(base[1:0]) ^ (n % 4));
    return {base[AW-1:2], 2'(lo)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    cpu_strb_n = 1'b1; ctl_strb_n = 1'b1; sel_n = 1'b0; sel2_n = 1'b0;
    adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bsel_n = '1;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic ctl_write(input int a, input logic [DW-1:0] d, input logic g,
                           input logic b, input logic [NL-1:0] bs, input logic adv);
    ctl_strb_n = 1'b0; cpu_strb_n = 1'b1; sel_n = 1'b0; sel2_n = 1'b0;
    addr = AW'(a); din = d; gw_n = g; bwe_n = b; bsel_n = bs; adv_n = adv;
    step();
    for (int i = 0; i < NL; i++)
      if (!g || (!b && !bs[i])) shadow[a][i*LW +: LW] = d[i*LW +: LW];
    idle();
  endtask

  task automatic read_back(input int a, input string tag);
    idle(); ctl_strb_n = 1'b0; addr = AW'(a);
    step();
    idle();
    step();
    chk(tag, 32'(dout), 32'(shadow[a]));
  endtask

  task automatic burst(input logic [AW-1:0] base, input logic lin, input string tag);
    lin_order = lin;
    idle(); ctl_strb_n = 1'b0; addr = base;
    step();
    for (int j = 1; j <= 4; j++) begin
      idle(); adv_n = 1'b0;
      step();
      chk(tag, 32'(dout), 32'(shadow[burst_at(base, j - 1, lin)]));
    end
    idle();
    step();
    chk(tag, 32'(dout), 32'(shadow[burst_at(base, 4, lin)]));
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; idle(); sel_n = 1'b1; oe_n = 1'b0; lin_order = 1'b1;
    addr = '0; din = '0;
    repeat (3) step();
    chk("R1 dout_en in reset", 32'(dout_en), 0);
    rst_n = 1'b1;
    cpu_strb_n = 1'b1; ctl_strb_n = 1'b1;
    repeat (2) step();
    chk("R1 dout_en idle after reset", 32'(dout_en), 0);

    // R8: fill every word with global write
    for (int a = 0; a < DEPTH; a++) ctl_write(a, pattern(a), 1'b0, 1'b1, '1, 1'b1);

    // R2: pipelined sweep of consecutive reads
    for (int a = 0; a < DEPTH; a++) begin
      idle(); ctl_strb_n = 1'b0; addr = AW'(a);
      step();
      if (a > 0) begin
        chk("R2 sweep data", 32'(dout), 32'(shadow[a-1]));
        chk("R2 sweep drive", 32'(dout_en), 1);
      end
    end
    idle();
    step();
    chk("R2 sweep last", 32'(dout), 32'(shadow[DEPTH-1]));

    // deselect, then processor-strobe read from idle
    idle(); ctl_strb_n = 1'b0; sel_n = 1'b1;
    step(); idle(); sel_n = 1'b1; step(); step();
    idle(); cpu_strb_n = 1'b0; addr = AW'(10);
    step();
    idle();
    chk("R4 first cycle off", 32'(dout_en), 0);
    step();
    chk("R2 cpu read data", 32'(dout), 32'(shadow[10]));
    chk("R2 cpu read drive", 32'(dout_en), 1);

    // R3: processor strobe with primary select high is ignored
    idle(); cpu_strb_n = 1'b0; sel_n = 1'b1; addr = AW'(20);
    step();
    idle();
    step();
    chk("R3 ignored strobe data", 32'(dout), 32'(shadow[10]));
    chk("R3 ignored strobe drive", 32'(dout_en), 1);
    chk("R13 hold data", 32'(dout), 32'(shadow[10]));

    // R11: asynchronous output enable
    oe_n = 1'b1; #1;
    chk("R11 oe high", 32'(dout_en), 0);
    oe_n = 1'b0; #1;
    chk("R11 oe low", 32'(dout_en), 1);

    // R5: double-cycle deselect
    idle(); ctl_strb_n = 1'b0; sel2_n = 1'b1;
    step();
    idle(); sel_n = 1'b1;
    chk("R5 still driving", 32'(dout_en), 1);
    step();
    chk("R5 off after second edge", 32'(dout_en), 0);

    // R6: two-cycle processor write; start-edge controls ignored
    idle(); cpu_strb_n = 1'b0; addr = AW'(30); gw_n = 1'b0; din = 16'h1111;
    step();
    idle(); bwe_n = 1'b0; bsel_n = 2'b10; din = 16'hABCD;
    step();
    shadow[30][7:0] = 8'hCD;
    chk("R10 quiet after write", 32'(dout_en), 0);
    idle();
    read_back(30, "R6 processor write");

    // R8: global write overrides byte controls
    ctl_write(31, 16'h1234, 1'b0, 1'b0, 2'b11, 1'b1);
    chk("R10 quiet after ctl write", 32'(dout_en), 0);
    read_back(31, "R8 global write");

    // R9: byte write to lane 1 only
    ctl_write(32, 16'hBEEF, 1'b1, 1'b0, 2'b01, 1'b1);
    read_back(32, "R9 lane mask");

    // R7: both strobes low -> read, no write
    idle(); cpu_strb_n = 1'b0; ctl_strb_n = 1'b0; addr = AW'(33);
    gw_n = 1'b0; din = 16'h0000;
    step();
    idle();
    step();
    chk("R7 processor strobe wins", 32'(dout), 32'(shadow[33]));

    // R7: advance ignored on controller write
    ctl_write(34, 16'h5A5A, 1'b0, 1'b1, '1, 1'b0);
    read_back(34, "R7 advance ignored");
    read_back(35, "R7 neighbour untouched");

    // R12: burst orders
    burst(AW'(41), 1'b1, "R12 linear burst");
    burst(AW'(45), 1'b0, "R12 interleaved burst");
    lin_order = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule